// File: doc/BRIEF.md
# Segmented Indexed Vector Multiply-Accumulate

This block decodes one 32-bit instruction word and performs a lane-wise integer multiply-accumulate across a vector of `VL` bits. `VL` must be a multiple of 128. The vector is viewed as a row of 128-bit segments. Each element of the first source is multiplied by one element of the second source. That multiplier is picked by an immediate lane index, and it comes from the same segment as the element it multiplies. The product is cut to the element width and added to the matching element of the addend vector. Elements may be 16, 32 or 64 bits wide, so a segment holds 8, 4 or 2 lanes.

A caller presents the instruction, the three operand vectors and `in_valid`. One cycle later the block returns, together with `out_valid`:
- the decoded register numbers;
- the element-size code;
- the lane index;
- the undefined flag;
- the result vector.

The block does not read or write a register file, so the caller uses the decoded numbers to fetch and retire operands. Every element is updated; there is no masking.

Top module: `seg_idx_mac`

## Requirements
- R1: A word is accepted only if bits 31:24 are 8'b01000100, bit 21 is 1 and bits 15:10 are 6'b000010. Any other word reports `out_undef`=1. It also returns `result` equal to the addend vector, and all decoded fields (size, index, registers) are zero.
- R2: When bit 23 is 0, the element size is 16 bits (size code 0). The index is {bit 22, bits 20:19}, and the second-source register is {1'b0, bits 18:16}.
- R3: When bits 23:22 are 2'b10, the element size is 32 bits (size code 1). The index is {1'b0, bits 20:19}, and the second-source register is {1'b0, bits 18:16}.
- R4: When bits 23:22 are 2'b11, the element size is 64 bits (size code 2). The index is {2'b00, bit 20}, and the second-source register is bits 19:16, so register 15 is reachable.
- R5: In every accepted form, the first-source register is bits 9:5 and the destination/addend register is bits 4:0.
- R6: Every element e of `result` is computed as addend[e] + (src_a[e] * src_b[base(e) + index]) mod 2^esize. Here base(e) = e - (e mod lanes_per_segment), and all elements are updated.
- R7: The result does not depend on a signed or unsigned reading of the inputs. For example, all-ones times all-ones gives 1 in each lane.
- R8: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. All outputs are registered together.
- R9: While `in_valid` is low, every output other than `out_valid` holds its value, whatever the inputs do.
- R10: After reset, `out_valid`, `out_undef`, every decoded field and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and instruction are present |
| instr | input | 32 | Instruction word |
| src_a | input | VL | First source vector (multiplicand) |
| src_b | input | VL | Second source vector (indexed multiplier) |
| addend | input | VL | Addend vector |
| out_valid | output | 1 | Registered results are fresh |
| out_undef | output | 1 | Word matched no accepted form |
| out_esz | output | 2 | Size code: 0=16, 1=32, 2=64 bits |
| out_idx | output | 3 | Lane index within a segment |
| out_rm | output | 4 | Second-source register number |
| out_rn | output | 5 | First-source register number |
| out_rd | output | 5 | Addend/destination register number |
| result | output | VL | Accumulated vector |

## Verification
A wrong index field or a wrong segment base makes whole segments take their multiplier from a neighbouring lane. That fault shows up in `result` on the `out_valid` cycle right after the operation. Random operands are used for every index value in every size, so such a fault cannot hide behind equal lanes. A bad decode stands out in the same cycle in `out_esz`, `out_idx` or the register fields. A fault in the hold path only shows one or more idle cycles later, when `result` drifts while `out_valid` is low.

// File: rtl/seg_idx_mac.sv
module seg_idx_mac #(
  parameter int VL = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [VL-1:0] src_a,
  input  logic [VL-1:0] src_b,
  input  logic [VL-1:0] addend,
  output logic          out_valid,
  output logic          out_undef,
  output logic [1:0]    out_esz,
  output logic [2:0]    out_idx,
  output logic [3:0]    out_rm,
  output logic [4:0]    out_rn,
  output logic [4:0]    out_rd,
  output logic [VL-1:0] result
);
  localparam int SEG  = 128;
  localparam int NSEG = VL / SEG;

  logic       base_ok, is_h, is_s, is_d;
  logic [1:0] d_esz;
  logic [2:0] d_idx;
  logic [3:0] d_rm;
  logic [4:0] d_rn, d_rd;

  assign base_ok = (instr[31:24] == 8'b01000100) && instr[21] && (instr[15:10] == 6'b000010);
  assign is_h = base_ok && !instr[23];
  assign is_s = base_ok && (instr[23:22] == 2'b10);
  assign is_d = base_ok && (instr[23:22] == 2'b11);

  assign d_esz = is_d ? 2'd2 : is_s ? 2'd1 : 2'd0;
  assign d_idx = is_h ? {instr[22], instr[20:19]} :
                 is_s ? {1'b0, instr[20:19]} :
                 is_d ? {2'b00, instr[20]} : 3'd0;
  assign d_rm  = is_d ? instr[19:16] : base_ok ? {1'b0, instr[18:16]} : 4'd0;
  assign d_rn  = base_ok ? instr[9:5] : 5'd0;
  assign d_rd  = base_ok ? instr[4:0] : 5'd0;

  logic [VL-1:0] mac_h, mac_s, mac_d, mac_sel;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [15:0] bh;
    logic [31:0] bs;
    logic [63:0] bd;
    assign bh = src_b[s*SEG + 16*d_idx +: 16];
    assign bs = src_b[s*SEG + 32*d_idx[1:0] +: 32];
    assign bd = src_b[s*SEG + 64*d_idx[0] +: 64];
    for (genvar j = 0; j < 8; j++) begin : g_h
      assign mac_h[s*SEG + j*16 +: 16] = addend[s*SEG + j*16 +: 16] + src_a[s*SEG + j*16 +: 16] * bh;
    end
    for (genvar j = 0; j < 4; j++) begin : g_s
      assign mac_s[s*SEG + j*32 +: 32] = addend[s*SEG + j*32 +: 32] + src_a[s*SEG + j*32 +: 32] * bs;
    end
    for (genvar j = 0; j < 2; j++) begin : g_d
      assign mac_d[s*SEG + j*64 +: 64] = addend[s*SEG + j*64 +: 64] + src_a[s*SEG + j*64 +: 64] * bd;
    end
  end

  assign mac_sel = !base_ok ? addend : is_d ? mac_d : is_s ? mac_s : mac_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
      out_esz   <= '0;
      out_idx   <= '0;
      out_rm    <= '0;
      out_rn    <= '0;
      out_rd    <= '0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_undef <= !base_ok;
        out_esz   <= d_esz;
        out_idx   <= d_idx;
        out_rm    <= d_rm;
        out_rn    <= d_rn;
        out_rd    <= d_rd;
        result    <= mac_sel;
      end
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R1
  undef_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !base_ok) |=> (out_undef && result == $past(addend) && out_esz == 2'd0));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(out_esz) && $stable(out_idx) && $stable(out_rm)));
  // R4
  wide_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_esz == 2'd2) |-> (out_idx[2:1] == 2'b00));
  // R2
  esz_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_esz != 2'd3));
endmodule

// File: tb/seg_idx_mac_tb.sv
module seg_idx_mac_tb_top;
  localparam int VL = 256;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [31:0]   instr = '0;
  logic [VL-1:0] src_a = '0, src_b = '0, addend = '0;
  logic          out_valid, out_undef;
  logic [1:0]    out_esz;
  logic [2:0]    out_idx;
  logic [3:0]    out_rm;
  logic [4:0]    out_rn, out_rd;
  logic [VL-1:0] result;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_idx_mac #(.VL(VL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .addend(addend),
    .out_valid(out_valid), .out_undef(out_undef), .out_esz(out_esz),
    .out_idx(out_idx), .out_rm(out_rm), .out_rn(out_rn), .out_rd(out_rd),
    .result(result));

  // entry: {size code[1:0], index[2:0], rm[3:0], rn[4:0], rd[4:0]}
  localparam logic [18:0] TBL [14] = '{
    {2'd0, 3'd0, 4'd7, 5'd1,  5'd2},
    {2'd0, 3'd1, 4'd0, 5'd31, 5'd0},
    {2'd0, 3'd2, 4'd3, 5'd4,  5'd5},
    {2'd0, 3'd3, 4'd5, 5'd6,  5'd31},
    {2'd0, 3'd4, 4'd1, 5'd8,  5'd9},
    {2'd0, 3'd5, 4'd2, 5'd10, 5'd11},
    {2'd0, 3'd6, 4'd6, 5'd12, 5'd13},
    {2'd0, 3'd7, 4'd7, 5'd14, 5'd15},
    {2'd1, 3'd0, 4'd7, 5'd16, 5'd17},
    {2'd1, 3'd1, 4'd4, 5'd18, 5'd19},
    {2'd1, 3'd2, 4'd0, 5'd20, 5'd21},
    {2'd1, 3'd3, 4'd6, 5'd22, 5'd23},
    {2'd2, 3'd0, 4'd15, 5'd24, 5'd25},
    {2'd2, 3'd1, 4'd9, 5'd26, 5'd27}
  };

  function automatic logic [31:0] mk(logic [1:0] sz, logic [2:0] ix, logic [3:0] rm,
                                     logic [4:0] rn, logic [4:0] rd);
    case (sz)
      2'd0:    mk = {8'h44, 1'b0, ix[2], 1'b1, ix[1:0], rm[2:0], 6'b000010, rn, rd};
      2'd1:    mk = {8'h44, 2'b10, 1'b1, ix[1:0], rm[2:0], 6'b000010, rn, rd};
      default: mk = {8'h44, 2'b11, 1'b1, ix[0], rm[3:0], 6'b000010, rn, rd};
    endcase
  endfunction

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] r;
    for (int i = 0; i < VL/32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [VL-1:0] ref_mac(int es, int ix, logic [VL-1:0] a,
                                            logic [VL-1:0] b, logic [VL-1:0] c);
    logic [VL-1:0] m, r, ae, be, ce;
    int eps;
    eps = 128 / es;
    m = ({{(VL-1){1'b0}}, 1'b1} << es) - 1;
    r = '0;
    for (int e = 0; e < VL/es; e++) begin
      int base;
      base = e - (e % eps);
      ae = (a >> (e*es)) & m;
      be = (b >> ((base + ix)*es)) & m;
      ce = (c >> (e*es)) & m;
      r = r | ((((ae * be) + ce) & m) << (e*es));
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [VL-1:0] act, logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(logic [31:0] w, logic [VL-1:0] a, logic [VL-1:0] b, logic [VL-1:0] c);
    @(negedge clk);
    instr = w; src_a = a; src_b = b; addend = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [VL-1:0] a, b, c, exp, held;
    logic [18:0] ent;
    logic [1:0] sz;
    logic [2:0] ix, eix;
    logic [3:0] rm, erm;
    logic [4:0] rn, rd;
    int es;
    string tg;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid == 0 && out_undef == 0, "R10 flags", {out_valid, out_undef}, 0);
    chk({out_esz, out_idx, out_rm, out_rn, out_rd} == 0, "R10 fields",
        {out_esz, out_idx, out_rm, out_rn, out_rd}, 0);
    chk(result == 0, "R10 result", result, 0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R8
    for (int t = 0; t < 14; t++) begin
      ent = TBL[t];
      {sz, ix, rm, rn, rd} = ent;
      es  = (sz == 2'd0) ? 16 : (sz == 2'd1) ? 32 : 64;
      eix = (sz == 2'd0) ? ix : (sz == 2'd1) ? {1'b0, ix[1:0]} : {2'b00, ix[0]};
      erm = (sz == 2'd2) ? rm : {1'b0, rm[2:0]};
      tg  = (sz == 2'd0) ? "R2" : (sz == 2'd1) ? "R3" : "R4";
      a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
      run_op(mk(sz, ix, rm, rn, rd), a, b, c);
      exp = ref_mac(es, int'(eix), a, b, c);
      chk(out_valid == 1'b1 && out_undef == 1'b0, "R8 valid", {out_valid, out_undef}, 2'b10);
      chk({out_esz, out_idx, out_rm} == {sz, eix, erm}, {tg, " decode"},
          {out_esz, out_idx, out_rm}, {sz, eix, erm});
      chk({out_rn, out_rd} == {rn, rd}, "R5 regs", {out_rn, out_rd}, {rn, rd});
      chk(result == exp, {"R6 result ", tg}, result, exp);
    end

    // R8 out_valid drops after an idle cycle
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 drop", out_valid, 0);

    // R9 hold while idle
    held = result;
    @(negedge clk);
    instr = mk(2'd1, 3'd2, 4'd3, 5'd1, 5'd1); src_a = rnd_vec(); src_b = rnd_vec(); addend = rnd_vec();
    repeat (2) @(negedge clk);
    chk(result == held, "R9 hold", result, held);

    // R7 sign-agnostic: all-ones squared plus zero gives one per lane
    run_op(mk(2'd0, 3'd3, 4'd0, 5'd0, 5'd0), '1, '1, '0);
    chk(result == {16{16'h0001}}, "R7 ones", result, {16{16'h0001}});
    // R7 (-2) * 3 in 64-bit lanes
    run_op(mk(2'd2, 3'd1, 4'd15, 5'd0, 5'd0), {4{64'hFFFF_FFFF_FFFF_FFFE}},
           {2{64'd3, 64'd9}}, '0);
    chk(result == {4{64'hFFFF_FFFF_FFFF_FFFA}}, "R7 neg", result, {4{64'hFFFF_FFFF_FFFF_FFFA}});

    // R1 undefined words
    for (int k = 0; k < 3; k++) begin
      logic [31:0] w;
      w = mk(2'd1, 3'd1, 4'd2, 5'd3, 5'd4);
      if (k == 0) w[21] = 1'b0;
      if (k == 1) w[31:24] = 8'h45;
      if (k == 2) w[15:10] = 6'b000011;
      a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
      run_op(w, a, b, c);
      chk(out_undef == 1'b1 && out_valid == 1'b1, "R1 flag", {out_undef, out_valid}, 2'b11);
      chk(result == c, "R1 passthrough", result, c);
      chk({out_esz, out_idx, out_rm, out_rn, out_rd} == 0, "R1 fields",
          {out_esz, out_idx, out_rm, out_rn, out_rd}, 0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule